// File: doc/BRIEF.md
# Priority Interrupt Presentation Unit

This block sits beside one processor and holds at most one interrupt waiting to be taken. Interrupt sources (through a separate source layer) offer deliveries, each carrying a source number and a priority. The unit answers each offer with an acknowledge or a refusal. It raises its interrupt line while it holds a pending source. When a more favoured offer arrives, the held source is pushed out and handed back to the source layer as a reject pulse. Priorities follow the rule that a smaller number is more favoured.

The processor works the unit through a one-cycle operation port. It can write the current processor priority, or write a self-interrupt priority that presents a fixed source number as an inter-processor interrupt. It can take the pending interrupt, which reads a combined word. It can retire an interrupt, which sends an end-of-interrupt pulse to the source layer. Whenever the processor opens its priority window with nothing held, the unit first re-checks the self-interrupt and then asks the source layer to send again any deliveries it refused earlier.

All widths, the self-interrupt source number and the tie rule between equal priorities are parameters. All answers and pulses are registered and appear in the cycle after the request.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the interrupt line is low, the current priority is 0, nothing is pending (a pending source number of 0 means empty), the pending priority is 0 and the self-interrupt priority is 0xFF, so no self-interrupt can be presented.
- R2: A delivery with source number 0, or with priority greater than or equal to the current priority, is refused (`dlv_nak`). An admitted delivery is acknowledged (`dlv_ack`), latched as the pending source and raises `irq_o`.
- R3: A delivery is also refused when a source is already held whose priority is less than or equal to the offered one; the held source stays.
- R4: An admitted delivery that finds a source held rejects the held source number through `rej_valid`/`rej_src`; `irq_o` is high exactly while a source is held.
- R5: The take operation (code 2) returns {current priority, pending source} in `rd_data`, with the priority in the top 8 bits and the source in the low 24 bits. It then clears the pending source, lowers `irq_o` and loads the current priority from the pending priority. `rd_data` holds its value until the next take.
- R6: The retire operation (code 3) pulses `eoi_valid` with `eoi_src` equal to the low 24 bits of the operand and sets the current priority to the operand's top 8 bits; with nothing held it then performs a resend.
- R7: Setting the current priority (code 0, value in operand bits 31:24) to a smaller value rejects and clears a held source whose priority is greater than or equal to the new value, and lowers `irq_o`.
- R8: Setting the current priority to a value greater than or equal to the old one with nothing held performs a resend, which pulses `resend_req`.
- R9: Writing the self-interrupt priority (code 1, value in operand bits 31:24) presents source number 2 at that priority when it is below the current priority, unless a held source has priority less than or equal to it. A source it displaces is rejected.
- R10: A resend first presents source number 2 at the self-interrupt priority when that priority is below the new current priority, and pulses `resend_req` in the same cycle.
- R11: A delivery offered in the same cycle as an operation is refused and leaves the held state untouched by the offer.
- R12: Acknowledge, refusal, reject, end-of-interrupt and resend outputs appear one cycle after the request and last one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dlv_valid | input | 1 | Delivery offer from the source layer |
| dlv_src | input | 24 | Offered source number |
| dlv_prio | input | 8 | Offered priority |
| dlv_ack | output | 1 | Offer admitted (one cycle later) |
| dlv_nak | output | 1 | Offer refused (one cycle later) |
| op_valid | input | 1 | Processor operation strobe |
| op_code | input | 2 | 0 set priority, 1 set self-interrupt priority, 2 take, 3 retire |
| op_data | input | 32 | Operand: priority in bits 31:24, source in bits 23:0 |
| rd_data | output | 32 | Word returned by the last take |
| irq_o | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse to the source layer |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source layer |
| eoi_src | output | 24 | Retired source number |
| resend_req | output | 1 | Resend request pulse to the source layer |

## Verification
On every cycle the assertions check the following: the interrupt line agrees with the held source, acknowledge and refusal never occur together and one of them follows every offer, an offer that collides with an operation is refused, a take leaves the line low, a retire forwards its source number, and a reject never names source 0. What only the bench scenarios can show is which source is held after a run of displacements, the exact word a take returns, the priority restored by take and retire, and whether a resend brings in the self-interrupt. The bench follows these through a long arithmetic sweep of mixed operations and offers over small priority and source ranges, checked against a model built from the requirements.

// File: rtl/irq_pu_pkg.sv
package irq_pu_pkg;

   typedef enum logic [1:0] {
      OP_SET_PRIO = 2'd0,
      OP_SET_IPI  = 2'd1,
      OP_TAKE     = 2'd2,
      OP_RETIRE   = 2'd3
   } pu_op_e;

endpackage

// File: rtl/irq_pu_admit.sv
// Decides whether a candidate priority passes the processor gate and
// beats the currently held source. Tie handling is a build option.
module irq_pu_admit #(
   parameter int PRIO_W   = 8,
   parameter bit TIE_HOLD = 1'b1
) (
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic [PRIO_W-1:0] gate_prio,
   input  logic              held_v,
   input  logic [PRIO_W-1:0] held_prio,
   output logic              take,
   output logic              displace
);
   logic beats_gate;
   logic beats_held;

   assign beats_gate = (cand_prio < gate_prio);

   generate
      if (TIE_HOLD) begin : g_tie_hold
         assign beats_held = (cand_prio < held_prio);
      end else begin : g_tie_swap
         assign beats_held = (cand_prio <= held_prio);
      end
   endgenerate

   assign take     = beats_gate && (!held_v || beats_held);
   assign displace = take && held_v;
endmodule

// File: rtl/irq_pu_next.sv
// Next-state and response logic for one presentation unit.
module irq_pu_next
   import irq_pu_pkg::*;
#(
   parameter int SRC_W    = 24,
   parameter int PRIO_W   = 8,
   parameter int IPI_SRC  = 2,
   parameter bit TIE_HOLD = 1'b1,
   localparam int WORD_W  = SRC_W + PRIO_W
) (
   input  logic [PRIO_W-1:0] cur_cppr,
   input  logic [SRC_W-1:0]  cur_src,
   input  logic [PRIO_W-1:0] cur_pprio,
   input  logic [PRIO_W-1:0] cur_ipi,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic [WORD_W-1:0] op_data,
   input  logic              dlv_valid,
   input  logic [SRC_W-1:0]  dlv_src,
   input  logic [PRIO_W-1:0] dlv_prio,
   output logic [PRIO_W-1:0] nxt_cppr,
   output logic [SRC_W-1:0]  nxt_src,
   output logic [PRIO_W-1:0] nxt_pprio,
   output logic [PRIO_W-1:0] nxt_ipi,
   output logic              rej_v,
   output logic [SRC_W-1:0]  rej_s,
   output logic              eoi_v,
   output logic [SRC_W-1:0]  eoi_s,
   output logic              resend,
   output logic              ack,
   output logic              nak,
   output logic              take_v,
   output logic [WORD_W-1:0] take_word
);
   localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

   pu_op_e            op;
   logic [PRIO_W-1:0] op_prio;
   logic [SRC_W-1:0]  op_src;
   logic              held;
   logic              dlv_take, dlv_disp;
   logic              ipiw_take, ipiw_disp;
   logic              ipir_take, unused_ipir_disp;

   assign op      = pu_op_e'(op_code);
   assign op_prio = op_data[WORD_W-1 -: PRIO_W];
   assign op_src  = op_data[SRC_W-1:0];
   assign held    = (cur_src != '0);

   // offered delivery against the present state
   irq_pu_admit #(.PRIO_W(PRIO_W), .TIE_HOLD(TIE_HOLD)) u_adm_dlv (
      .cand_prio (dlv_prio),
      .gate_prio (cur_cppr),
      .held_v    (held),
      .held_prio (cur_pprio),
      .take      (dlv_take),
      .displace  (dlv_disp)
   );

   // self-interrupt priority write against the present state
   irq_pu_admit #(.PRIO_W(PRIO_W), .TIE_HOLD(TIE_HOLD)) u_adm_ipiw (
      .cand_prio (op_prio),
      .gate_prio (cur_cppr),
      .held_v    (held),
      .held_prio (cur_pprio),
      .take      (ipiw_take),
      .displace  (ipiw_disp)
   );

   // self-interrupt re-check during a resend, gated by the new priority
   irq_pu_admit #(.PRIO_W(PRIO_W), .TIE_HOLD(TIE_HOLD)) u_adm_ipir (
      .cand_prio (cur_ipi),
      .gate_prio (op_prio),
      .held_v    (held),
      .held_prio (cur_pprio),
      .take      (ipir_take),
      .displace  (unused_ipir_disp)
   );

   always_comb begin
      nxt_cppr  = cur_cppr;
      nxt_src   = cur_src;
      nxt_pprio = cur_pprio;
      nxt_ipi   = cur_ipi;
      rej_v     = 1'b0;
      rej_s     = '0;
      eoi_v     = 1'b0;
      eoi_s     = '0;
      resend    = 1'b0;
      ack       = 1'b0;
      nak       = 1'b0;
      take_v    = 1'b0;
      take_word = {cur_cppr, cur_src};

      if (op_valid) begin
         unique case (op)
            OP_SET_PRIO: begin
               nxt_cppr = op_prio;
               if (op_prio < cur_cppr) begin
                  if (held && (op_prio <= cur_pprio)) begin
                     rej_v   = 1'b1;
                     rej_s   = cur_src;
                     nxt_src = '0;
                  end
               end else if (!held) begin
                  resend = 1'b1;
                  if (ipir_take) begin
                     nxt_src   = IPI_NUM;
                     nxt_pprio = cur_ipi;
                  end
               end
            end
            OP_SET_IPI: begin
               nxt_ipi = op_prio;
               if (ipiw_take) begin
                  if (ipiw_disp) begin
                     rej_v = 1'b1;
                     rej_s = cur_src;
                  end
                  nxt_src   = IPI_NUM;
                  nxt_pprio = op_prio;
               end
            end
            OP_TAKE: begin
               take_v   = 1'b1;
               nxt_src  = '0;
               nxt_cppr = cur_pprio;
            end
            OP_RETIRE: begin
               eoi_v    = 1'b1;
               eoi_s    = op_src;
               nxt_cppr = op_prio;
               if (!held) begin
                  resend = 1'b1;
                  if (ipir_take) begin
                     nxt_src   = IPI_NUM;
                     nxt_pprio = cur_ipi;
                  end
               end
            end
            default: ;
         endcase
      end

      if (dlv_valid) begin
         if (op_valid || (dlv_src == '0) || !dlv_take) begin
            nak = 1'b1;
         end else begin
            ack = 1'b1;
            if (dlv_disp) begin
               rej_v = 1'b1;
               rej_s = cur_src;
            end
            nxt_src   = dlv_src;
            nxt_pprio = dlv_prio;
         end
      end
   end
endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit #(
   parameter int SRC_W    = 24,
   parameter int PRIO_W   = 8,
   parameter int IPI_SRC  = 2,
   parameter bit TIE_HOLD = 1'b1,
   localparam int WORD_W  = SRC_W + PRIO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dlv_valid,
   input  logic [SRC_W-1:0]  dlv_src,
   input  logic [PRIO_W-1:0] dlv_prio,
   output logic              dlv_ack,
   output logic              dlv_nak,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic [WORD_W-1:0] op_data,
   output logic [WORD_W-1:0] rd_data,
   output logic              irq_o,
   output logic              rej_valid,
   output logic [SRC_W-1:0]  rej_src,
   output logic              eoi_valid,
   output logic [SRC_W-1:0]  eoi_src,
   output logic              resend_req
);
   // elaboration-time parameter checks
   generate
      if (SRC_W < 2 || SRC_W > 32) begin : g_bad_src_w
         $error("irq_present_unit: SRC_W out of range");
      end
      if (PRIO_W < 2 || PRIO_W > 16) begin : g_bad_prio_w
         $error("irq_present_unit: PRIO_W out of range");
      end
      if (IPI_SRC <= 0 || IPI_SRC >= (2 ** SRC_W)) begin : g_bad_ipi
         $error("irq_present_unit: IPI_SRC must be a nonzero source number");
      end
   endgenerate

   logic [PRIO_W-1:0] cppr_q, pprio_q, ipi_q;
   logic [SRC_W-1:0]  pend_src_q;
   logic [PRIO_W-1:0] cppr_n, pprio_n, ipi_n;
   logic [SRC_W-1:0]  src_n;
   logic              rej_n, eoi_n, resend_n, ack_n, nak_n, take_n;
   logic [SRC_W-1:0]  rej_s_n, eoi_s_n;
   logic [WORD_W-1:0] take_word_n;

   irq_pu_next #(
      .SRC_W    (SRC_W),
      .PRIO_W   (PRIO_W),
      .IPI_SRC  (IPI_SRC),
      .TIE_HOLD (TIE_HOLD)
   ) u_next (
      .cur_cppr  (cppr_q),
      .cur_src   (pend_src_q),
      .cur_pprio (pprio_q),
      .cur_ipi   (ipi_q),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .op_data   (op_data),
      .dlv_valid (dlv_valid),
      .dlv_src   (dlv_src),
      .dlv_prio  (dlv_prio),
      .nxt_cppr  (cppr_n),
      .nxt_src   (src_n),
      .nxt_pprio (pprio_n),
      .nxt_ipi   (ipi_n),
      .rej_v     (rej_n),
      .rej_s     (rej_s_n),
      .eoi_v     (eoi_n),
      .eoi_s     (eoi_s_n),
      .resend    (resend_n),
      .ack       (ack_n),
      .nak       (nak_n),
      .take_v    (take_n),
      .take_word (take_word_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cppr_q     <= '0;
         pend_src_q <= '0;
         pprio_q    <= '0;
         ipi_q      <= '1;
         irq_o      <= 1'b0;
         rd_data    <= '0;
         dlv_ack    <= 1'b0;
         dlv_nak    <= 1'b0;
         rej_valid  <= 1'b0;
         rej_src    <= '0;
         eoi_valid  <= 1'b0;
         eoi_src    <= '0;
         resend_req <= 1'b0;
      end else begin
         cppr_q     <= cppr_n;
         pend_src_q <= src_n;
         pprio_q    <= pprio_n;
         ipi_q      <= ipi_n;
         irq_o      <= (src_n != '0);
         if (take_n) begin
            rd_data <= take_word_n;
         end
         dlv_ack    <= ack_n;
         dlv_nak    <= nak_n;
         rej_valid  <= rej_n;
         rej_src    <= rej_s_n;
         eoi_valid  <= eoi_n;
         eoi_src    <= eoi_s_n;
         resend_req <= resend_n;
      end
   end
endmodule

// File: rtl/irq_pu_chk.sv
module irq_pu_chk
   import irq_pu_pkg::*;
#(
   parameter int SRC_W   = 24,
   parameter int PRIO_W  = 8,
   localparam int WORD_W = SRC_W + PRIO_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dlv_valid,
   input logic              dlv_ack,
   input logic              dlv_nak,
   input logic              op_valid,
   input logic [1:0]        op_code,
   input logic [WORD_W-1:0] op_data,
   input logic              irq_o,
   input logic              rej_valid,
   input logic [SRC_W-1:0]  rej_src,
   input logic              eoi_valid,
   input logic [SRC_W-1:0]  eoi_src,
   input logic [SRC_W-1:0]  pend_src
);
   p_line_tracks_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (pend_src != '0));

   p_answer_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(dlv_ack && dlv_nak));

   p_offer_answered_r12: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |=> (dlv_ack ^ dlv_nak));

   p_ack_raises_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_ack |-> irq_o);

   p_op_blocks_offer_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && op_valid) |=> dlv_nak);

   p_take_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_TAKE && !dlv_valid) |=> !irq_o);

   p_retire_forwards_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_RETIRE)
      |=> (eoi_valid && eoi_src == $past(op_data[SRC_W-1:0])));

   p_reject_named_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rej_valid |-> (rej_src != '0));

   p_idle_ipi_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_SET_IPI && (&op_data[WORD_W-1 -: PRIO_W]) && !dlv_valid)
      |=> !rej_valid);
endmodule

bind irq_present_unit irq_pu_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dlv_valid (dlv_valid),
   .dlv_ack   (dlv_ack),
   .dlv_nak   (dlv_nak),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .op_data   (op_data),
   .irq_o     (irq_o),
   .rej_valid (rej_valid),
   .rej_src   (rej_src),
   .eoi_valid (eoi_valid),
   .eoi_src   (eoi_src),
   .pend_src  (pend_src_q)
);

// File: tb/irq_present_unit_tb_top.sv
`timescale 1ns/1ps
module irq_present_unit_tb_top;
   localparam int SW = 24;
   localparam int PW = 8;
   localparam int WW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dlv_valid = 1'b0;
   logic [SW-1:0] dlv_src = '0;
   logic [PW-1:0] dlv_prio = '0;
   logic          dlv_ack, dlv_nak;
   logic          op_valid = 1'b0;
   logic [1:0]    op_code = '0;
   logic [WW-1:0] op_data = '0;
   logic [WW-1:0] rd_data;
   logic          irq_o, rej_valid, eoi_valid, resend_req;
   logic [SW-1:0] rej_src, eoi_src;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // independent model state
   logic [PW-1:0] m_c = 8'h00, m_pp = 8'h00, m_ipi = 8'hFF;
   logic [SW-1:0] m_x = '0;
   logic [WW-1:0] m_rd = '0;

   always #2.5 clk = ~clk;

   irq_present_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
      .dlv_ack(dlv_ack), .dlv_nak(dlv_nak),
      .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
      .rd_data(rd_data), .irq_o(irq_o),
      .rej_valid(rej_valid), .rej_src(rej_src),
      .eoi_valid(eoi_valid), .eoi_src(eoi_src),
      .resend_req(resend_req)
   );

   function automatic bit wins(logic [PW-1:0] cand, logic [PW-1:0] gate,
                               logic [SW-1:0] held, logic [PW-1:0] hp);
      return (cand < gate) && ((held == '0) || (cand < hp));
   endfunction

   task automatic chk(string tag, string req, string what,
                      logic [WW-1:0] act, logic [WW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s %s: got %h expected %h", tag, req, what, act, exp);
      end
   endtask

   task automatic model_resend(output bit res);
      res = 1'b1;
      if (m_ipi < m_c) begin
         m_x  = SW'(2);
         m_pp = m_ipi;
      end
   endtask

   // Called at a negedge: drives one request, samples at the next negedge.
   task automatic step(string tag, bit ov, logic [1:0] oc, logic [WW-1:0] od,
                       bit dv, logic [SW-1:0] ds, logic [PW-1:0] dp);
      logic [PW-1:0] op_p;
      bit e_ack, e_nak, e_rj, e_eo, e_res;
      logic [SW-1:0] e_rs, e_es;
      op_p  = od[WW-1 -: PW];
      e_ack = 0; e_nak = 0; e_rj = 0; e_eo = 0; e_res = 0;
      e_rs  = '0; e_es = '0;
      if (dv) begin
         if (ov || ds == '0 || !wins(dp, m_c, m_x, m_pp)) e_nak = 1;
         else e_ack = 1;
      end
      if (ov) begin
         case (oc)
            2'd0: begin
               if (op_p < m_c) begin
                  if (m_x != '0 && op_p <= m_pp) begin
                     e_rj = 1; e_rs = m_x; m_x = '0;
                  end
                  m_c = op_p;
               end else begin
                  m_c = op_p;
                  if (m_x == '0) model_resend(e_res);
               end
            end
            2'd1: begin
               m_ipi = op_p;
               if (wins(op_p, m_c, m_x, m_pp)) begin
                  if (m_x != '0) begin e_rj = 1; e_rs = m_x; end
                  m_x = SW'(2); m_pp = op_p;
               end
            end
            2'd2: begin
               m_rd = {m_c, m_x}; m_x = '0; m_c = m_pp;
            end
            default: begin
               e_eo = 1; e_es = od[SW-1:0]; m_c = op_p;
               if (m_x == '0) model_resend(e_res);
            end
         endcase
      end
      if (e_ack) begin
         if (m_x != '0) begin e_rj = 1; e_rs = m_x; end
         m_x = ds; m_pp = dp;
      end
      op_valid = ov; op_code = oc; op_data = od;
      dlv_valid = dv; dlv_src = ds; dlv_prio = dp;
      @(negedge clk);
      chk(tag, "R4", "irq_o", WW'(irq_o), WW'(m_x != '0));
      chk(tag, "R2", "dlv_ack", WW'(dlv_ack), WW'(e_ack));
      chk(tag, "R2", "dlv_nak", WW'(dlv_nak), WW'(e_nak));
      chk(tag, "R4", "rej_valid", WW'(rej_valid), WW'(e_rj));
      if (e_rj) chk(tag, "R4", "rej_src", WW'(rej_src), WW'(e_rs));
      chk(tag, "R6", "eoi_valid", WW'(eoi_valid), WW'(e_eo));
      if (e_eo) chk(tag, "R6", "eoi_src", WW'(eoi_src), WW'(e_es));
      chk(tag, "R8", "resend_req", WW'(resend_req), WW'(e_res));
      chk(tag, "R5", "rd_data", rd_data, m_rd);
      op_valid = 0; dlv_valid = 0;
   endtask

   function automatic logic [WW-1:0] w(logic [PW-1:0] p, logic [SW-1:0] s);
      return {p, s};
   endfunction

   task automatic idle(string tag);
      step(tag, 0, 2'd0, '0, 0, '0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R1");                                 // reset state
      // R6 and R8: retire with nothing held opens the window, resend pulses
      step("R6", 1, 2'd3, w(8'hFF, 24'd5), 0, '0, '0);
      // R2: refusals on priority gate and source 0, then an admit
      step("R2", 0, 2'd0, '0, 1, 24'd9, 8'hFF);
      step("R2", 0, 2'd0, '0, 1, 24'd0, 8'h03);
      step("R2", 0, 2'd0, '0, 1, 24'd9, 8'h0A);
      // R3: tie and less favoured offers refused while 9 is held
      step("R3", 0, 2'd0, '0, 1, 24'd11, 8'h0A);
      step("R3", 0, 2'd0, '0, 1, 24'd11, 8'h0C);
      // R4: more favoured offer displaces 9
      step("R4", 0, 2'd0, '0, 1, 24'd12, 8'h04);
      // R11: offer collides with an operation
      step("R11", 1, 2'd1, w(8'hFF, '0), 1, 24'd13, 8'h01);
      // R5: take returns {FF,12}, priority becomes 4
      step("R5", 1, 2'd2, '0, 0, '0, '0);
      // R7: hold 20 at 2, then tighten priority to 2 rejects it
      step("R7", 0, 2'd0, '0, 1, 24'd20, 8'h02);
      step("R7", 1, 2'd0, w(8'h02, '0), 0, '0, '0);
      // R8: loosen with nothing held
      step("R8", 1, 2'd0, w(8'h80, '0), 0, '0, '0);
      // R9: self-interrupt presented, then skipped, then displaced twice
      step("R9", 1, 2'd1, w(8'h30, '0), 0, '0, '0);
      step("R9", 1, 2'd1, w(8'h40, '0), 0, '0, '0);
      step("R9", 0, 2'd0, '0, 1, 24'd7, 8'h10);
      step("R9", 1, 2'd1, w(8'h08, '0), 0, '0, '0);
      // R10: take the self-interrupt, retire it; resend re-presents it
      step("R10", 1, 2'd2, '0, 0, '0, '0);
      step("R10", 1, 2'd3, w(8'h90, 24'd2), 0, '0, '0);
      // R12: pulses last one cycle
      idle("R12");
      // arithmetic sweep over mixed traffic in small ranges
      for (int i = 0; i < 3000; i++) begin
         int k;
         logic [PW-1:0] opp;
         k   = (i * 37 + 11) % 23;
         opp = ((i * 7) % 17 == 16) ? 8'hFF : PW'((i * 7) % 17);
         step("SWEEP", k < 12, 2'(k % 4), w(opp, SW'((i * 3) % 9)),
              (i % 3) != 0, SW'((i * 5) % 7), PW'((i * 11) % 13));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R12: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule